// File: doc/BRIEF.md
# Second-Order Comb Decimator for a One-Bit Modulator Stream

This block turns the single-bit output of a delta-sigma modulator into a 24-bit signed fixed-point reading. A divider derives the modulator sample rate from the master clock. Each sample is mapped to +1 or -1 and fed through a cascade of two integrators and two differentiators. The result is therefore a triangular-weighted average over the last 2N-1 samples, and one reading appears every N samples. A 3-bit code chooses N, which also sets the first notch of the response. Longer windows give slower readings and deeper rejection of low-frequency interference.

The reading is scaled so that a stream of all ones gives +1.0 and a stream of all zeros gives -1.0. The binary point sits below bit 22. When the rate code changes, or the converter is switched off, the filter state is cleared. The first readings that follow would mix in stale history, so they are suppressed.

Top module: `sinc2_decimator`

## Requirements
- R1: While `en` is high, one modulator sample is taken every CLK_DIV master cycles (default 48, giving about 83.33 kHz from 4 MHz). The first sample is taken on the CLK_DIV-th rising edge after `en` rises.
- R2: A sampled `mod_bit` of 1 counts as +1 and a 0 counts as -1. The filter output is the sum of the last 2N-1 samples, weighted 1, 2, ..., N, ..., 2, 1 with the newest sample weighted 1.
- R3: The window length is N = 2^(BASE_LOG+code). With the default BASE_LOG of 9, codes 000 to 101 give 512 to 16384 taps. Codes 110 and 111 select the same length as 101.
- R4: Exactly one reading is produced per N samples. `result_valid` is high for the single cycle that follows the edge that takes the N-th sample.
- R5: `result` is 24-bit two's complement with 2^22 representing 1.0. An all-ones stream reads 0x400000 and an all-zeros stream reads 0xC00000.
- R6: The raw sum is multiplied by 2^(22-2·log2 N). When that exponent is negative, the division is an arithmetic shift that rounds toward minus infinity.
- R7: While `en` is low, no samples are taken, no reading is produced and the filter state is cleared. The discard rule of R8 applies again after `en` rises.
- R8: A change of `rate_sel` clears the filter on the next edge. The first two readings after that are suppressed, and the third is the first one output.
- R9: `result` keeps its value in every cycle in which `result_valid` is low.
- R10: After reset, `result` is zero and `result_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| mod_bit | input | 1 | Modulator output bit |
| rate_sel | input | 3 | Window length code |
| result | output | 24 | Signed fixed-point reading |
| result_valid | output | 1 | One-cycle strobe for a new reading |

## Verification
The bench keeps a history of every bit it drives. It recomputes each reading from the triangular weights, so a design with a shifted window or a missing integrator stage gives wrong values on random and alternating streams. Full-scale streams in both polarities pin the scaling: a wrong shift gives a value other than 0x400000 or 0xC00000. Rate changes in the middle of a window, codes 110 and 111, and a disabled interval all test the flush and discard logic. A design that kept stale state or discarded too few readings would strobe early or report a mixed value. The bench also checks for the absence of a strobe at every sample boundary, which catches strobes that come a sample early, come twice, or come while the converter is off.

// File: rtl/sinc2_decimator_pkg.sv
package sinc2_decimator_pkg;

   typedef logic [2:0] rate_code_t;

   // Window length exponent for a rate code; codes above the last one clamp.
   function automatic int tap_log(input rate_code_t code, input int base, input int ncodes);
      int c;
      c = int'(code);
      if (c > ncodes - 1) c = ncodes - 1;
      return base + c;
   endfunction

endpackage

// File: rtl/sample_tick_gen.sv
module sample_tick_gen #(
   parameter int CLK_DIV = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == LAST);
endmodule

// File: rtl/comb_chain.sv
module comb_chain #(
   parameter int ORDER = 2,
   parameter int ACC_W = 30
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    sample_en,
   input  logic                    bit_in,
   input  logic                    dump,
   output logic signed [ACC_W-1:0] comb_out
);
   logic signed [ACC_W-1:0] integ [ORDER];
   logic signed [ACC_W-1:0] isum  [ORDER];
   logic signed [ACC_W-1:0] dly   [ORDER];
   logic signed [ACC_W-1:0] csum  [ORDER];
   logic signed [ACC_W-1:0] x_val;

   assign x_val = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

   always_comb begin
      isum[0] = integ[0] + x_val;
      for (int k = 1; k < ORDER; k++) isum[k] = integ[k] + isum[k-1];
      csum[0] = isum[ORDER-1] - dly[0];
      for (int k = 1; k < ORDER; k++) csum[k] = csum[k-1] - dly[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < ORDER; k++) begin
            integ[k] <= '0;
            dly[k]   <= '0;
         end
      end else if (clear) begin
         for (int k = 0; k < ORDER; k++) begin
            integ[k] <= '0;
            dly[k]   <= '0;
         end
      end else begin
         if (sample_en)
            for (int k = 0; k < ORDER; k++) integ[k] <= isum[k];
         if (dump) begin
            dly[0] <= isum[ORDER-1];
            for (int k = 1; k < ORDER; k++) dly[k] <= csum[k-1];
         end
      end
   end

   assign comb_out = csum[ORDER-1];
endmodule

// File: rtl/fixed_point_scaler.sv
module fixed_point_scaler #(
   parameter int ORDER   = 2,
   parameter int ACC_W   = 30,
   parameter int MAX_LOG = 14,
   parameter int LOG_W   = 4,
   parameter int OUT_W   = 24,
   parameter int FRAC    = 22
) (
   input  logic signed [ACC_W-1:0] raw,
   input  logic [LOG_W-1:0]        len_log,
   output logic [OUT_W-1:0]        scaled
);
   localparam int WIDE = ACC_W + FRAC + 1;

   logic signed [WIDE-1:0] wide_in;
   logic signed [WIDE-1:0] wide_out;
   int                     sh;

   assign wide_in = {{(WIDE-ACC_W){raw[ACC_W-1]}}, raw};
   assign sh      = FRAC - ORDER * int'(len_log);

   generate
      if (ORDER * MAX_LOG <= FRAC) begin : g_left_only
         always_comb wide_out = wide_in <<< sh;
      end else begin : g_both_ways
         always_comb begin
            if (sh >= 0) wide_out = wide_in <<< sh;
            else         wide_out = wide_in >>> (-sh);
         end
      end
   endgenerate

   assign scaled = wide_out[OUT_W-1:0];
endmodule

// File: rtl/sinc2_decimator.sv
module sinc2_decimator
   import sinc2_decimator_pkg::*;
#(
   parameter int CLK_DIV   = 48,
   parameter int BASE_LOG  = 9,
   parameter int NUM_CODES = 6,
   parameter int ORDER     = 2,
   parameter int OUT_W     = 24,
   parameter int FRAC      = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             mod_bit,
   input  logic [2:0]       rate_sel,
   output logic [OUT_W-1:0] result,
   output logic             result_valid
);
   localparam int MAX_LOG = BASE_LOG + NUM_CODES - 1;
   localparam int ACC_W   = ORDER * MAX_LOG + 2;
   localparam int LOG_W   = $clog2(MAX_LOG + 1);
   localparam int DISC_W  = $clog2(ORDER + 1);

   generate
      if (CLK_DIV < 2)                    begin : g_bad_div   $error("CLK_DIV must be at least 2"); end
      if (NUM_CODES < 1 || NUM_CODES > 8) begin : g_bad_codes $error("NUM_CODES must be 1..8"); end
      if (ORDER < 1 || ORDER > 4)         begin : g_bad_order $error("ORDER must be 1..4"); end
      if (FRAC >= OUT_W - 1)              begin : g_bad_frac  $error("FRAC leaves no room for 1.0"); end
      if (BASE_LOG < 1)                   begin : g_bad_base  $error("BASE_LOG must be positive"); end
   endgenerate

   rate_code_t          rate_q;
   logic                flush;
   logic                tick;
   logic                last;
   logic                dec;
   logic [LOG_W-1:0]    cur_log;
   logic [MAX_LOG:0]    n_minus1;
   logic [MAX_LOG-1:0]  samp_cnt;
   logic [DISC_W-1:0]   disc;
   logic signed [ACC_W-1:0] raw_sum;
   logic [OUT_W-1:0]    scaled;

   assign flush    = !en || (rate_sel != rate_q);
   assign cur_log  = LOG_W'(tap_log(rate_q, BASE_LOG, NUM_CODES));
   assign n_minus1 = ({{MAX_LOG{1'b0}}, 1'b1} << cur_log) - 1'b1;
   assign last     = ({1'b0, samp_cnt} == n_minus1);
   assign dec      = tick && last && !flush;

   sample_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .tick  (tick)
   );

   comb_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (flush),
      .sample_en (tick && !flush),
      .bit_in    (mod_bit),
      .dump      (dec),
      .comb_out  (raw_sum)
   );

   fixed_point_scaler #(
      .ORDER(ORDER), .ACC_W(ACC_W), .MAX_LOG(MAX_LOG),
      .LOG_W(LOG_W), .OUT_W(OUT_W), .FRAC(FRAC)
   ) u_scale (
      .raw     (raw_sum),
      .len_log (cur_log),
      .scaled  (scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q       <= '0;
         samp_cnt     <= '0;
         disc         <= '0;
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         rate_q       <= rate_sel;
         if (flush) begin
            samp_cnt <= '0;
            disc     <= '0;
         end else if (tick) begin
            if (last) begin
               samp_cnt <= '0;
               if (disc == DISC_W'(ORDER)) begin
                  result       <= scaled;
                  result_valid <= 1'b1;
               end else begin
                  disc <= disc + 1'b1;
               end
            end else begin
               samp_cnt <= samp_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sinc2_decimator_checker.sv
module sinc2_decimator_checker #(
   parameter int OUT_W = 24,
   parameter int FRAC  = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [2:0]       rate_sel,
   input logic [OUT_W-1:0] result,
   input logic             result_valid
);
   localparam logic signed [OUT_W-1:0] POS_FS = OUT_W'(1) <<< FRAC;
   localparam logic signed [OUT_W-1:0] NEG_FS = -POS_FS;

   // R4: strobe lasts one cycle
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   // R7: nothing produced while disabled
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !result_valid);

   // R8: a code change flushes, so no strobe follows immediately
   a_r8_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel != $past(rate_sel)) |=> !result_valid);

   // R5: readings stay within plus or minus full scale
   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> ($signed(result) <= POS_FS && $signed(result) >= NEG_FS));

   // R9: reading holds between strobes
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> $stable(result));
endmodule

bind sinc2_decimator sinc2_decimator_checker #(.OUT_W(OUT_W), .FRAC(FRAC)) u_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (en),
   .rate_sel     (rate_sel),
   .result       (result),
   .result_valid (result_valid)
);

// File: tb/sinc2_decimator_test.sv
module sinc2_decimator_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 3;
   localparam int BL         = 2;
   localparam int HIST       = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        mod_bit = 1'b0;
   logic [2:0]  rate_sel = 3'd0;
   logic [23:0] result;
   logic        result_valid;

   int hist [HIST];
   int nsamp = 0;
   int cur_code = 0;
   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sinc2_decimator #(.CLK_DIV(DIV), .BASE_LOG(BL)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .mod_bit(mod_bit),
      .rate_sel(rate_sel), .result(result), .result_valid(result_valid)
   );

   function automatic int len_log(input int code);
      return BL + ((code > 5) ? 5 : code);
   endfunction

   // Triangular-weighted sum of the history, scaled to 1.0 = 2^22 (R2, R5, R6)
   function automatic longint expected_value(input int lg);
      longint raw = 0;
      int n = 1 << lg;
      int sh = 22 - 2 * lg;
      for (int d = 0; d < 2 * n - 1; d++) begin
         int w = (d < n) ? d + 1 : 2 * n - 1 - d;
         raw += longint'(w) * longint'(hist[(nsamp - 1 - d) % HIST]);
      end
      if (sh >= 0) return raw <<< sh;
      return raw >>> (-sh);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive one sample; starts and ends at a falling edge
   task automatic do_sample(input bit b, input string req);
      int lg;
      int n;
      mod_bit = b;
      repeat (DIV) @(posedge clk);
      @(negedge clk);
      hist[nsamp % HIST] = b ? 1 : -1;
      nsamp++;
      lg = len_log(cur_code);
      n = 1 << lg;
      if ((nsamp % n) == 0 && (nsamp / n) >= 3) begin
         longint e = expected_value(lg);
         check(result_valid == 1'b1, {req, " strobe"}, result_valid, 1);
         check(longint'($signed(result)) == e, {req, " value"}, longint'($signed(result)), e);
      end else begin
         check(result_valid == 1'b0, {req, " R4 no strobe"}, result_valid, 0);
      end
   endtask

   task automatic run(input int count, input int mode, input string req);
      for (int i = 0; i < count; i++) begin
         bit b;
         case (mode)
            0: b = 1'b1;
            1: b = 1'b0;
            2: b = 1'($urandom % 2);
            default: b = 1'(i % 2);
         endcase
         do_sample(b, req);
      end
   endtask

   task automatic set_rate(input int code);
      rate_sel = 3'(code);
      if (code != cur_code) nsamp = 0;
      cur_code = code;
   endtask

   task automatic disabled(input int cycles);
      en = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         @(posedge clk);
         @(negedge clk);
         check(result_valid == 1'b0, "R7 idle", result_valid, 0);
      end
      en = 1'b1;
      nsamp = 0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      longint held;
      void'($urandom(32'd7411));
      repeat (3) @(negedge clk);
      check(result == 24'd0, "R10 result", result, 0);
      check(result_valid == 1'b0, "R10 valid", result_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(result == 24'd0 && !result_valid, "R10 after release", result, 0);

      // R1/R5: N=4, full scale both ways
      en = 1'b1;
      set_rate(0);
      run(24, 0, "R1");
      check(result == 24'h400000, "R5 plus one", result, 24'h400000);
      run(24, 1, "R5");
      check(result == 24'hC00000, "R5 minus one", result, 24'hC00000);

      // R2: random and alternating streams
      set_rate(2);
      run(16 * 6, 2, "R2");
      set_rate(3);
      run(32 * 5, 3, "R2");

      // R3/R6: longest window and clamped codes
      set_rate(5);
      run(128 * 5, 2, "R3");
      set_rate(7);
      run(128 * 4, 0, "R3");
      check(result == 24'h400000, "R3 code 7 full scale", result, 24'h400000);
      set_rate(6);
      run(128 * 4, 2, "R6");

      // R8: change in the middle of a window
      set_rate(1);
      run(8 * 2 + 3, 2, "R8");
      set_rate(4);
      run(64 * 4, 2, "R8");

      // R7/R9: disabled interval, hold, restart
      held = longint'(result);
      disabled(40);
      check(longint'(result) == held, "R9 hold", longint'(result), held);
      run(64 * 4, 0, "R7");

      // constrained random mix
      for (int it = 0; it < 20; it++) begin
         int code = int'($urandom % 5);
         int n = 1 << len_log(code);
         set_rate(code);
         run(n * (3 + int'($urandom % 3)) + int'($urandom % n), int'($urandom % 4), "R2");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule